// File: doc/BRIEF.md
# Four-Switch Buck-Boost Gate PWM

This block produces the four gate commands for a single-inductor, four-switch buck-boost power stage. The stage has two half-bridge legs. The input-side (buck) leg and the output-side (boost) leg each have a high-side and a low-side switch. A free-running carrier counter, divided down from the system clock, sets the switching period. A duty command is compared against the carrier to give a raw leg level. A per-leg dead-time stage then turns that level into a complementary pair of outputs that never overlap.

The duty command comes either from a closed-loop tracking controller or from a fixed open-loop value, chosen by a select input. The operating mode picks which leg switches. In buck mode the input leg switches and the output leg conducts straight through. In boost mode the roles are swapped. In pass-through mode both legs conduct straight through. Duty, source, mode and both dead times are sampled once per period, on its last clock. A synchronous reset and a disable input force every output low.

Top module: `bbsw_pwm`

## Requirements
- R1: A synchronous reset drives all four outputs low from the first clock edge at which it is seen. After reset the captured settings are: duty 255, turn-on gap 3, turn-off gap 3, buck mode, carrier position 0. These settings govern the first period after release.
- R2: The period is CLK_HZ/PWM_HZ clocks, where PWM_HZ defaults to 220 kHz. For a 9-bit duty d with 0 < d < 511, the raw level of a switching leg is high for the first floor(d*period/512) clocks of each period. The outputs follow the carrier with one clock of latency.
- R3: With `ol_sel` = 1 the duty is taken from `ol_duty`. With `ol_sel` = 0 it is taken from `trk_duty`.
- R4: Duty, source select, mode and both gap settings are sampled only on the last clock of a period. A change at any other time has no effect until the next period begins.
- R5: Mode 0 (buck): the input leg switches and the output leg's raw level is held high. Mode 1 (boost): the output leg switches and the input leg's raw level is held high. Modes 2 and 3 (pass-through): both raw levels are held high.
- R6: When a leg's raw level rises, its low side turns off on the same edge and its high side turns on `ton` clocks later. A raw pulse shorter than the gap gives no high-side pulse.
- R7: When a leg's raw level falls, its high side turns off on the same edge and its low side turns on `toff` clocks later.
- R8: Within a leg, the high-side and low-side outputs are never both high in the same cycle.
- R9: Duty 0 holds a switching leg's low side steadily on. Duty 511 holds its high side steadily on. Neither produces any dead-time gap within the period.
- R10: While `dis` is sampled high, all four outputs are low. The dead-time state keeps tracking, so the outputs resume in phase once `dis` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dis | input | 1 | Global output disable, active high |
| ol_sel | input | 1 | 1 selects the open-loop duty |
| ol_duty | input | 9 | Open-loop duty value |
| trk_duty | input | 9 | Duty from the tracking controller |
| mode | input | 2 | 0 buck, 1 boost, 2 or 3 pass-through |
| ton | input | 3 | Gap in clocks before a high side turns on |
| toff | input | 3 | Gap in clocks before a low side turns on |
| buck_hi | output | 1 | Input leg high-side gate |
| buck_lo | output | 1 | Input leg low-side gate |
| boost_hi | output | 1 | Output leg high-side gate |
| boost_lo | output | 1 | Output leg low-side gate |

## Verification
The settings capture at the end of a period can land on the same clock as a leg's dead-time countdown. The new gap values and mode then meet a gap that the old values started. This is provoked by rewriting duty, mode, source and both gaps every seven clocks, so that the changes fall at every offset against the carrier. A bench model that counts elapsed clocks since each level change judges every cycle. The same model also judges the disable input when it arrives in the middle of a gap.

// File: rtl/bbsw_pkg.sv
`timescale 1ns/1ps
package bbsw_pkg;

  typedef enum logic [1:0] {
    MODE_BUCK     = 2'd0,
    MODE_BOOST    = 2'd1,
    MODE_PASS     = 2'd2,
    MODE_PASS_ALT = 2'd3
  } mode_e;

  // clocks of high level for a duty value within one carrier period
  function automatic int unsigned on_clocks(int unsigned duty, int unsigned period,
                                            int unsigned duty_w);
    return (duty * period) >> duty_w;
  endfunction

  // raw leg level at carrier position pos; zero and full scale are static
  function automatic logic carrier_level(int unsigned pos, int unsigned duty,
                                         int unsigned period, int unsigned duty_w);
    int unsigned full;
    full = (32'd1 << duty_w) - 32'd1;
    if (duty == 32'd0) return 1'b0;
    if (duty == full) return 1'b1;
    return pos < on_clocks(duty, period, duty_w);
  endfunction

  // input leg conducts straight through unless the mode switches it
  function automatic logic buck_leg_held(mode_e m);
    return m != MODE_BUCK;
  endfunction

  // output leg conducts straight through unless the mode switches it
  function automatic logic boost_leg_held(mode_e m);
    return m != MODE_BOOST;
  endfunction

endpackage

// File: rtl/bbsw_carrier.sv
`timescale 1ns/1ps
module bbsw_carrier #(
  parameter int unsigned PERIOD = 909,
  parameter int unsigned PW     = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pos,
  output logic          wrap
);

  assign wrap = (pos == PW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (wrap) pos <= '0;
    else           pos <= pos + 1'b1;
  end

endmodule

// File: rtl/bbsw_cmd.sv
`timescale 1ns/1ps
module bbsw_cmd #(
  parameter int unsigned DUTY_W    = 9,
  parameter int unsigned DT_W      = 3,
  parameter int unsigned DUTY_INIT = 255,
  parameter int unsigned DT_INIT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              ol_sel,
  input  logic [DUTY_W-1:0] ol_duty,
  input  logic [DUTY_W-1:0] trk_duty,
  input  logic [1:0]        mode_in,
  input  logic [DT_W-1:0]   ton_in,
  input  logic [DT_W-1:0]   toff_in,
  output logic [DUTY_W-1:0] duty_q,
  output logic [1:0]        mode_q,
  output logic [DT_W-1:0]   ton_q,
  output logic [DT_W-1:0]   toff_q
);

  logic [DUTY_W-1:0] duty_pick;
  assign duty_pick = ol_sel ? ol_duty : trk_duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= DUTY_W'(DUTY_INIT);
      mode_q <= bbsw_pkg::MODE_BUCK;
      ton_q  <= DT_W'(DT_INIT);
      toff_q <= DT_W'(DT_INIT);
    end else if (take) begin
      duty_q <= duty_pick;
      mode_q <= mode_in;
      ton_q  <= ton_in;
      toff_q <= toff_in;
    end
  end

endmodule

// File: rtl/bbsw_leg.sv
`timescale 1ns/1ps
module bbsw_leg #(
  parameter int unsigned DT_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dis,
  input  logic            demand,
  input  logic [DT_W-1:0] ton,
  input  logic [DT_W-1:0] toff,
  output logic            hi,
  output logic            lo
);

  logic            lvl_q;
  logic [DT_W-1:0] gap_q;
  logic [DT_W-1:0] gap_n;
  logic            level_change;
  logic            settled;

  assign level_change = (demand != lvl_q);

  always_comb begin
    if (level_change)      gap_n = demand ? ton : toff;
    else if (gap_q != '0)  gap_n = gap_q - 1'b1;
    else                   gap_n = gap_q;
  end

  assign settled = (gap_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else begin
      lvl_q <= demand;
      gap_q <= gap_n;
      hi    <= !dis && demand && settled;
      lo    <= !dis && !demand && settled;
    end
  end

  assert_leg_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));

  // a high side may rise straight out of a low-side phase only with a zero gap
  assert_on_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hi) |-> (!$past(lo) || ($past(ton) == '0)));

  assert_off_gap_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lo) |-> (!$past(hi) || ($past(toff) == '0)));

endmodule

// File: rtl/bbsw_pwm.sv
`timescale 1ns/1ps
module bbsw_pwm #(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned PWM_HZ    = 220_000,
  parameter int unsigned DUTY_W    = 9,
  parameter int unsigned DT_W      = 3,
  parameter int unsigned DUTY_INIT = 255,
  parameter int unsigned DT_INIT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dis,
  input  logic              ol_sel,
  input  logic [DUTY_W-1:0] ol_duty,
  input  logic [DUTY_W-1:0] trk_duty,
  input  logic [1:0]        mode,
  input  logic [DT_W-1:0]   ton,
  input  logic [DT_W-1:0]   toff,
  output logic              buck_hi,
  output logic              buck_lo,
  output logic              boost_hi,
  output logic              boost_lo
);

  localparam int unsigned PERIOD = CLK_HZ / PWM_HZ;
  localparam int unsigned PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned LEGS   = 2;

  logic [PW-1:0]     pos;
  logic              wrap;
  logic              at_start;
  logic [DUTY_W-1:0] duty_q;
  logic [1:0]        mode_q;
  logic [DT_W-1:0]   ton_q;
  logic [DT_W-1:0]   toff_q;
  logic              pwm_lvl;
  logic [LEGS-1:0]   held;
  logic [LEGS-1:0]   dem;
  logic [LEGS-1:0]   hi;
  logic [LEGS-1:0]   lo;

  bbsw_carrier #(.PERIOD(PERIOD), .PW(PW)) u_carrier (
    .clk  (clk),
    .rst  (rst),
    .pos  (pos),
    .wrap (wrap)
  );

  bbsw_cmd #(
    .DUTY_W(DUTY_W), .DT_W(DT_W), .DUTY_INIT(DUTY_INIT), .DT_INIT(DT_INIT)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .take     (wrap),
    .ol_sel   (ol_sel),
    .ol_duty  (ol_duty),
    .trk_duty (trk_duty),
    .mode_in  (mode),
    .ton_in   (ton),
    .toff_in  (toff),
    .duty_q   (duty_q),
    .mode_q   (mode_q),
    .ton_q    (ton_q),
    .toff_q   (toff_q)
  );

  assign at_start = (pos == '0);
  assign pwm_lvl  = bbsw_pkg::carrier_level(32'(pos), 32'(duty_q), PERIOD, DUTY_W);
  assign held[0]  = bbsw_pkg::buck_leg_held(bbsw_pkg::mode_e'(mode_q));
  assign held[1]  = bbsw_pkg::boost_leg_held(bbsw_pkg::mode_e'(mode_q));

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign dem[g] = held[g] | pwm_lvl;

    bbsw_leg #(.DT_W(DT_W)) u_leg (
      .clk    (clk),
      .rst    (rst),
      .dis    (dis),
      .demand (dem[g]),
      .ton    (ton_q),
      .toff   (toff_q),
      .hi     (hi[g]),
      .lo     (lo[g])
    );

    // a raw level can only rise where new settings take effect
    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(dem[g]) |-> at_start);
  end

  assign buck_hi  = hi[0];
  assign buck_lo  = lo[0];
  assign boost_hi = hi[1];
  assign boost_lo = lo[1];

  logic rst_d;
  logic dis_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    dis_d <= dis;
  end

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_low_R1: assert ({buck_hi, buck_lo, boost_hi, boost_lo} == 4'b0000);
    end
    if (dis_d) begin
      assert_disable_low_R10: assert ({buck_hi, buck_lo, boost_hi, boost_lo} == 4'b0000);
    end
  end

endmodule

// File: tb/sim_bbsw_pwm.sv
`timescale 1ns/1ps
module sim_bbsw_pwm;

  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned PWM_HZ = 5_000_000;
  localparam int P    = CLK_HZ / PWM_HZ;
  localparam int FULL = 511;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dis = 1'b0;
  logic ol_sel = 1'b0;
  logic [8:0] ol_duty = '0;
  logic [8:0] trk_duty = '0;
  logic [1:0] mode = '0;
  logic [2:0] ton = '0;
  logic [2:0] toff = '0;
  logic buck_hi, buck_lo, boost_hi, boost_lo;

  always #2.5 clk = ~clk;

  bbsw_pwm #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ)) u0 (
    .clk(clk), .rst(rst), .dis(dis), .ol_sel(ol_sel), .ol_duty(ol_duty),
    .trk_duty(trk_duty), .mode(mode), .ton(ton), .toff(toff),
    .buck_hi(buck_hi), .buck_lo(buck_lo), .boost_hi(boost_hi), .boost_lo(boost_lo)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // behavioural reference: elapsed clocks since each leg's last level change
  int m_pos, m_duty, m_mode, m_ton, m_toff;
  int lvl[2], age[2], need[2];
  bit e_hi[2], e_lo[2];
  bit pw;
  bit want[2];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_pos = 0; m_duty = 255; m_mode = 0; m_ton = 3; m_toff = 3;
      for (int i = 0; i < 2; i++) begin
        lvl[i] = 0; age[i] = 0; need[i] = 0; e_hi[i] = 0; e_lo[i] = 0;
      end
    end else begin
      if (m_duty == 0) pw = 0;
      else if (m_duty == FULL) pw = 1;
      else pw = (m_pos < (m_duty * P) / 512);
      want[0] = (m_mode == 0) ? pw : 1'b1;
      want[1] = (m_mode == 1) ? pw : 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (int'(want[i]) != lvl[i]) begin
          lvl[i] = int'(want[i]);
          age[i] = 0;
          need[i] = want[i] ? m_ton : m_toff;
        end else if (age[i] < 15) begin
          age[i]++;
        end
        e_hi[i] = !dis && (lvl[i] == 1) && (age[i] >= need[i]);
        e_lo[i] = !dis && (lvl[i] == 0) && (age[i] >= need[i]);
      end
      if (m_pos == P - 1) begin
        m_duty = ol_sel ? int'(ol_duty) : int'(trk_duty);
        m_mode = int'(mode);
        m_ton  = int'(ton);
        m_toff = int'(toff);
        m_pos  = 0;
      end else begin
        m_pos++;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(tag, {28'd0, buck_hi, buck_lo, boost_hi, boost_lo},
          {28'd0, e_hi[0], e_lo[0], e_hi[1], e_lo[1]});
      chk("R8", {31'd0, (buck_hi & buck_lo) | (boost_hi & boost_lo)}, 32'd0);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog req=all got=%0d exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    while (m_pos != 0) @(negedge clk);
  endtask

  task automatic tally(output int bh, output int bl, output int oh, output int ol);
    bh = 0; bl = 0; oh = 0; ol = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      bh += int'(buck_hi); bl += int'(buck_lo);
      oh += int'(boost_hi); ol += int'(boost_lo);
    end
  endtask

  int bh, bl, oh, ol, ht;

  initial begin
    mode = 2'd1; trk_duty = 9'd100; ton = 3'd1; toff = 3'd2;
    step(4);
    chk("R1", {28'd0, buck_hi, buck_lo, boost_hi, boost_lo}, 32'd0);
    rst = 1'b0;
    // first period runs on reset settings: duty 255, gaps 3, buck mode
    tally(bh, bl, oh, ol);
    ht = (255 * P) / 512;
    chk("R1", bh, ht - 3);
    chk("R1", bl, P - ht - 3);
    chk("R1", oh, P - 3);
    chk("R1", ol, 0);

    tag = "R2";
    ol_sel = 0; trk_duty = 9'd100; mode = 2'd0; ton = 3'd2; toff = 3'd2;
    step(3 * P);
    trk_duty = 9'd400; step(2 * P);
    trk_duty = 9'd1;   step(2 * P);

    tag = "R3";
    ol_sel = 1; ol_duty = 9'd300; trk_duty = 9'd50;
    step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R3", bh, (300 * P) / 512 - 2);
    ol_sel = 0;
    step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R3", bh, ((50 * P) / 512 > 2) ? (50 * P) / 512 - 2 : 0);

    tag = "R5";
    mode = 2'd1; step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R5", bh, P); chk("R5", bl, 0);
    mode = 2'd2; step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R5", bh, P); chk("R5", oh, P);
    mode = 2'd3; step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R5", bh + oh, 2 * P); chk("R5", bl + ol, 0);

    tag = "R6";
    mode = 2'd0; trk_duty = 9'd256; ton = 3'd0; toff = 3'd0;
    step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R6", bh + bl, P);
    ton = 3'd7; toff = 3'd5;
    step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R6", bh, (256 * P) / 512 - 7);
    chk("R7", bl, P - (256 * P) / 512 - 5);
    trk_duty = 9'd20;
    step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R6", bh, 0);

    tag = "R4";
    for (int i = 0; i < 40; i++) begin
      trk_duty = 9'((i * 37) % 512);
      ol_duty  = 9'((i * 91) % 512);
      ol_sel   = i[0];
      mode     = 2'(i % 3);
      ton      = 3'(i % 8);
      toff     = 3'((i * 3) % 8);
      dis      = (i % 11 == 5);
      step(7);
    end
    dis = 0; ol_sel = 0; mode = 2'd0; trk_duty = 9'd256; ton = 3'd2; toff = 3'd2;
    step(3 * P); align();
    trk_duty = 9'd511;
    tally(bh, bl, oh, ol);
    chk("R4", bh, (256 * P) / 512 - 2);
    tally(bh, bl, oh, ol);
    chk("R4", bh, P - 2);

    tag = "R9";
    trk_duty = 9'd0; step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R9", bh, 0); chk("R9", bl, P);
    trk_duty = 9'd511; step(3 * P); align(); tally(bh, bl, oh, ol);
    chk("R9", bh, P); chk("R9", bl, 0);

    tag = "R10";
    trk_duty = 9'd200;
    step(2 * P);
    dis = 1; step(2); tally(bh, bl, oh, ol);
    chk("R10", bh + bl + oh + ol, 0);
    dis = 0; step(2 * P);
    dis = 1; step(3); dis = 0; step(2 * P);

    tag = "R1";
    step(13);
    rst = 1; step(1);
    chk("R1", {28'd0, buck_hi, buck_lo, boost_hi, boost_lo}, 32'd0);
    step(2); rst = 0;
    step(3 * P);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule